// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block drives a single DRAM bank. It remembers whether a row is currently held open in the bank's sense amplifiers and, if so, which row. Each read or write request arrives as a row, a column and a direction bit. The block compares the request against the remembered row and places it in one of three cases.

- **Hit:** the requested row is already open.
- **Closed:** no row is open.
- **Conflict:** some other row is open.

It then emits the command chain for that case, one command per cycle on a command output. A conflict needs a precharge, then an activate, then a column access. A closed bank needs an activate and then a column access. A hit needs only the column access. After each command the block waits the interval set on its timing inputs before issuing the next one.

A request is taken with a valid/ready handshake, and only one request is in flight at a time. When the column-access interval has elapsed, the block pulses a completion flag that carries the case it chose, and it is ready again in that same cycle. The three timing intervals are inputs, so they can be reprogrammed between requests.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, done is 0, and the bank counts as closed, so the first request is classified closed (done_kind 1).
- R2: Closed bank (done_kind 1): an activate (cmd_op 2) appears in the cycle after acceptance. The column command follows t_ras cycles later, and done follows t_cas cycles after that.
- R3: Hit (done_kind 0): only a column command is issued, in the cycle after acceptance, and done follows t_cas cycles after it.
- R4: Conflict (done_kind 2): a precharge (cmd_op 1) appears in the cycle after acceptance. An activate follows t_rp cycles later, then a column command t_ras cycles after that, then done t_cas cycles after the column command.
- R5: The column command uses cmd_op 3 for a read (req_write 0) and 4 for a write (req_write 1). Every command carries the accepted request's row on cmd_row and its column on cmd_col.
- R6: req_ready is 0 from acceptance until the done cycle. A req_valid asserted while req_ready is 0 issues no command and leaves the tracked open row unchanged.
- R7: The tracked open row changes only when an activate or a precharge is issued. After a conflict has opened a new row, the next request to that row is a hit.
- R8: A timing input of 0 is treated as an interval of 1 cycle.
- R9: Each command is asserted on cmd_valid for exactly one cycle. done is a single-cycle pulse, and done_kind is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_ras | input | TW | Interval from activate to column command, in cycles |
| t_cas | input | TW | Interval from column command to completion, in cycles |
| t_rp | input | TW | Interval from precharge to activate, in cycles |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cmd_valid | output | 1 | A command is issued in this cycle |
| cmd_op | output | 3 | 0 none, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| done | output | 1 | Single-cycle completion pulse |
| done_kind | output | 2 | Case of the finished request: 0 hit, 1 closed, 2 conflict |

## Verification
The hardest situation to reach from the ports is a row conflict that falls right after a stray request was offered while the block was busy. If the stray request slipped through, it would change the remembered row. To reach this case, the stimulus first opens one row, then opens another row through a conflict. During the busy window of that conflict it holds req_valid high with an unrelated row. It then checks that the following request to the conflict's row classifies as a hit and that no extra command appeared. The zero-interval case is reached by reprogramming all three timing inputs to 0 between requests.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_PRE = 3'd1,
    OP_ACT = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    K_HIT      = 2'd0,
    K_CLOSED   = 2'd1,
    K_CONFLICT = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_W,
    ST_ACT,
    ST_ACT_W,
    ST_CAS,
    ST_CAS_W
  } st_e;
endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == {{(TW-1){1'b0}}, 1'b1});

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/dbs_open_row.sv
module dbs_open_row
  import dbs_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic             cas_fire,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [ROW_W-1:0] probe_row,
  output kind_e            probe_kind
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;

  always_comb begin
    open_d = open_q;
    if (act_fire)      open_d = 1'b1;
    else if (pre_fire) open_d = 1'b0;
    row_en = act_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= cmd_row;
  end

  always_comb begin
    if (!open_q)                 probe_kind = K_CLOSED;
    else if (row_q == probe_row) probe_kind = K_HIT;
    else                         probe_kind = K_CONFLICT;
  end

  // R2
  act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !open_q);
  // R4
  pre_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |-> open_q);
  // R5
  cas_row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fire |-> (open_q && row_q == cmd_row));
  // R7
  act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> (open_q && row_q == $past(cmd_row)));
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    t_ras,
  input  logic [TW-1:0]    t_cas,
  input  logic [TW-1:0]    t_rp,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  kind_e            probe_kind,
  input  logic             tmr_last,
  output logic             req_ready,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             act_fire,
  output logic             pre_fire,
  output logic             cas_fire,
  output logic             cmd_valid,
  output op_e              cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done,
  output kind_e            done_kind
);
  st_e              st_q, st_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  kind_e            kind_q;
  logic             accept, finish;
  logic             done_q;
  kind_e            dkind_q;
  logic [TW-1:0]    ras_m1, cas_m1, rp_m1;

  // a programmed 0 behaves like 1
  always_comb begin
    ras_m1 = (t_ras == '0) ? '0 : t_ras - 1'b1;
    cas_m1 = (t_cas == '0) ? '0 : t_cas - 1'b1;
    rp_m1  = (t_rp  == '0) ? '0 : t_rp  - 1'b1;
  end

  assign accept = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    finish   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (probe_kind)
            K_HIT:    st_d = ST_CAS;
            K_CLOSED: st_d = ST_ACT;
            default:  st_d = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = rp_m1;
        st_d     = (rp_m1 == '0) ? ST_ACT : ST_PRE_W;
      end
      ST_PRE_W: if (tmr_last) st_d = ST_ACT;
      ST_ACT: begin
        tmr_load = 1'b1;
        tmr_val  = ras_m1;
        st_d     = (ras_m1 == '0) ? ST_CAS : ST_ACT_W;
      end
      ST_ACT_W: if (tmr_last) st_d = ST_CAS;
      ST_CAS: begin
        tmr_load = 1'b1;
        tmr_val  = cas_m1;
        if (cas_m1 == '0) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end else begin
          st_d = ST_CAS_W;
        end
      end
      ST_CAS_W: begin
        if (tmr_last) begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      kind_q <= K_HIT;
    end else if (accept) begin
      row_q  <= req_row;
      col_q  <= req_col;
      wr_q   <= req_write;
      kind_q <= probe_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dkind_q <= K_HIT;
    else if (finish) dkind_q <= kind_q;
  end

  always_comb begin
    pre_fire  = (st_q == ST_PRE);
    act_fire  = (st_q == ST_ACT);
    cas_fire  = (st_q == ST_CAS);
    cmd_valid = pre_fire || act_fire || cas_fire;
    if (pre_fire)      cmd_op = OP_PRE;
    else if (act_fire) cmd_op = OP_ACT;
    else if (cas_fire) cmd_op = wr_q ? OP_WR : OP_RD;
    else               cmd_op = OP_NOP;
  end

  assign req_ready = (st_q == ST_IDLE);
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
  assign done      = done_q;
  assign done_kind = dkind_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_valid && !req_ready));
  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_op != $past(cmd_op)));
  // R3
  hit_cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && probe_kind == K_HIT) |=> cas_fire);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    t_ras,
  input  logic [TW-1:0]    t_cas,
  input  logic [TW-1:0]    t_rp,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done,
  output logic [1:0]       done_kind
);
  logic          srst_n;
  logic          tmr_load, tmr_last;
  logic [TW-1:0] tmr_val;
  logic          act_fire, pre_fire, cas_fire;
  kind_e         probe_kind;
  op_e           op_w;
  kind_e         dkind_w;

  dbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  dbs_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .load_val(tmr_val),
    .last(tmr_last)
  );

  dbs_open_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(srst_n), .act_fire(act_fire), .pre_fire(pre_fire),
    .cas_fire(cas_fire), .cmd_row(cmd_row), .probe_row(req_row),
    .probe_kind(probe_kind)
  );

  dbs_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .t_ras(t_ras), .t_cas(t_cas), .t_rp(t_rp),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .probe_kind(probe_kind), .tmr_last(tmr_last),
    .req_ready(req_ready), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .act_fire(act_fire), .pre_fire(pre_fire), .cas_fire(cas_fire),
    .cmd_valid(cmd_valid), .cmd_op(op_w), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .done(done), .done_kind(dkind_w)
  );

  assign cmd_op    = op_w;
  assign done_kind = dkind_w;
endmodule

// File: tb/dram_bank_seq_test.sv
`timescale 1ns/1ps
module dram_bank_seq_test;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int TW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TW-1:0]    t_ras = 8'd4, t_cas = 8'd2, t_rp = 8'd3;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_write = 1'b0;
  logic             cmd_valid;
  logic [2:0]       cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             done;
  logic [1:0]       done_kind;

  int checks = 0, errors = 0, cyc = 0, ev_n = 0, d_n = 0;
  int ev_cyc [64]; int ev_op [64]; int ev_row [64]; int ev_col [64];
  int d_cyc [64]; int d_kind [64];
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .t_ras(t_ras), .t_cas(t_cas), .t_rp(t_rp),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .req_col(req_col), .req_write(req_write), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .done(done),
    .done_kind(done_kind)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_valid && ev_n < 64) begin
      ev_cyc[ev_n] = cyc; ev_op[ev_n] = int'(cmd_op);
      ev_row[ev_n] = int'(cmd_row); ev_col[ev_n] = int'(cmd_col);
      ev_n++;
    end
    if (done && d_n < 64) begin
      d_cyc[d_n] = cyc; d_kind[d_n] = int'(done_kind); d_n++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [TW-1:0] t);
    return (t == '0) ? 1 : int'(t);
  endfunction

  // one request, optionally with a stray request offered while busy (R6)
  task automatic run_req(input int row, input int col, input bit wr,
                         input int exp_kind, input string rq, input bit junk);
    int n0, d0, acc, off, ne, guard;
    int xop [3]; int xcyc [3];
    n0 = ev_n; d0 = d_n;
    @(negedge clk);
    req_valid = 1'b1; req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
    req_write = wr;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk); #1 acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      req_valid = 1'b1; req_row = 14'd77; req_col = 10'd5; req_write = 1'b1;
      chk(req_ready == 1'b0, "R6", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R6", "ready while busy", int'(req_ready), 0);
      req_valid = 1'b0;
    end
    guard = 0;
    while (d_n == d0 && guard < 200) begin @(negedge clk); guard++; end
    // expected chain
    ne = 0; off = 0;
    if (exp_kind == 2) begin xop[ne] = 1; xcyc[ne] = acc + off; ne++; off += eff(t_rp); end
    if (exp_kind != 0) begin xop[ne] = 2; xcyc[ne] = acc + off; ne++; off += eff(t_ras); end
    xop[ne] = wr ? 4 : 3; xcyc[ne] = acc + off; ne++; off += eff(t_cas);
    chk(ev_n - n0 == ne, rq, "command count", ev_n - n0, ne);
    for (int i = 0; i < ne && i < ev_n - n0; i++) begin
      chk(ev_op[n0+i] == xop[i], rq, "command op", ev_op[n0+i], xop[i]);
      chk(ev_cyc[n0+i] == xcyc[i], rq, "command cycle", ev_cyc[n0+i], xcyc[i]);
      chk(ev_row[n0+i] == row, "R5", "command row", ev_row[n0+i], row);
      chk(ev_col[n0+i] == col, "R5", "command col", ev_col[n0+i], col);
    end
    chk(d_n - d0 == 1, "R9", "done pulses", d_n - d0, 1);
    if (d_n > d0) begin
      chk(d_cyc[d0] == acc + off, rq, "done cycle", d_cyc[d0], acc + off);
      chk(d_kind[d0] == exp_kind, rq, "done kind", d_kind[d0], exp_kind);
    end
    chk(req_ready == 1'b1, "R6", "ready at done", int'(req_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    chk(d_n - d0 == 1, "R9", "done pulses after", d_n - d0, 1);
  endtask

  task automatic test_reset;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "cmd after reset", int'(cmd_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic test_closed; run_req(5, 17, 1'b0, 1, "R2", 1'b0); endtask
  task automatic test_hit;    run_req(5, 33, 1'b1, 0, "R3", 1'b0); endtask
  task automatic test_conflict;
    run_req(9, 2, 1'b0, 2, "R4", 1'b0);
    run_req(9, 3, 1'b1, 0, "R7", 1'b0);
  endtask
  task automatic test_busy_ignored;
    run_req(5, 8, 1'b1, 2, "R6", 1'b1);
    run_req(5, 9, 1'b0, 0, "R6", 1'b0);
  endtask
  task automatic test_retime;
    t_rp = 8'd1; t_ras = 8'd6; t_cas = 8'd3;
    run_req(2, 100, 1'b0, 2, "R4", 1'b0);
  endtask
  task automatic test_zero;
    t_rp = 8'd0; t_ras = 8'd0; t_cas = 8'd0;
    run_req(3, 1, 1'b1, 2, "R8", 1'b0);
    run_req(3, 4, 1'b0, 0, "R8", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_closed();
    test_hit();
    test_conflict();
    test_busy_ignored();
    test_retime();
    test_zero();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule